// File: doc/BRIEF.md
# Immediate Encodability Checker

This block decides whether a 64-bit constant fits one of seven immediate-operand categories of a 64-bit load-store instruction set: arithmetic, logical bitmask, move-wide, PC-relative byte offset, shift amount, size-scaled unsigned load/store offset and signed indexed offset. It also returns the field values an encoder would place in the instruction. For shifted forms this is the shift amount. For bitmask forms it is the element size, the count of ones and the right-rotation.

A request is presented with a valid/ready handshake. Ready is always high, so one request can be accepted on every clock. The verdict appears in registers one cycle after acceptance, marked by a single-cycle valid pulse. It then stays unchanged until the next accepted request. The category is selected by a 3-bit kind code. Load/store scaling uses a 2-bit access-size code.

Top module: `imm_fit_checker`

## Requirements
- R1: `req_ready_o` is always 1. An accepted request makes `res_valid_o` high for exactly the next cycle, and the result fields are loaded at that edge. Without an accepted request, `res_valid_o` is 0 and all result fields keep their values. After reset, every output register is 0.
- R2: Kind 0 (arithmetic) is legal for a value up to 0xfff, which gives shift 0. Otherwise it is legal for a value up to 0xfff shifted left by 12 with its low 12 bits zero, which gives shift 12. 0xfff is legal and 0x1fff is illegal.
- R3: Kind 1 (logical) is legal only when the 64-bit value is an element of 2, 4, 8, 16, 32 or 64 bits repeated to fill the word. That element must hold a single contiguous run of ones, counted cyclically, together with at least one zero. 0xf0f0f0f0f0f0f0f0 is legal. 0xfeedfeedfeedfeed, all-zeros and all-ones are illegal.
- R4: For a legal bitmask result, `res_pattern_o` is 1. `res_esize_o` is the smallest element size that reproduces the value, and `res_ones_o` is the count of ones in that element. `res_rot_o` is the right-rotation that turns the element, with its ones packed at bit 0, into the actual element. Each of these three fields is less than `res_esize_o`, except that the element size itself is a power of two from 2 to 64.
- R5: Kind 2 (move-wide) is legal when the value is a 16-bit quantity shifted left by 0, 16, 32 or 48. `res_shift_o` reports the lowest such shift, and the value 0 gives shift 0. 0x8765 is legal with shift 0.
- R6: A kind 2 value that fits no shift is still legal if it meets R3. It then reports bitmask fields as in R4, with shift 0. 0x88888 is illegal.
- R7: Kind 3 (PC-relative) is legal when the value, read as two's complement, lies in -0x100000 to 0xfffff.
- R8: Kind 4 (shift amount) is legal only for the values 0 to 63. 0x4f is illegal.
- R9: Kind 5 (scaled load/store) uses `req_size_i` to select the access size: 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8. The offset is legal when it is a multiple of the access size and the quotient is at most 0xfff. `res_shift_o` then equals `req_size_i`. With size 3, 0x7ff8 is legal and 0x7ff4 is illegal.
- R10: Kind 6 (indexed) is legal when the value, read as two's complement, lies in -0x100 to 0xff. -0xff is legal and 0x1ff is illegal.
- R11: Kind 7 is always illegal. For any illegal result, `res_pattern_o`, `res_shift_o`, `res_esize_o`, `res_ones_o` and `res_rot_o` are all 0. For a legal non-bitmask result, the three bitmask fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (constant 1) |
| req_kind_i | input | 3 | Category code 0..7 |
| req_size_i | input | 2 | Access size code for kind 5 |
| req_value_i | input | 64 | Candidate constant |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_legal_o | output | 1 | Constant is encodable |
| res_pattern_o | output | 1 | Result encoded as bitmask |
| res_shift_o | output | 6 | Shift or scale amount |
| res_esize_o | output | 7 | Bitmask element size |
| res_ones_o | output | 7 | Ones in bitmask element |
| res_rot_o | output | 6 | Bitmask right-rotation |

## Verification
Two events can fall in the same cycle: the result pulse of one request and the acceptance of the next. In that cycle the result registers must take the new verdict and must not hold the old one. The bench provokes this with long back-to-back bursts in which the kinds and values change on every cycle. It also mixes in idle gaps, so that each reload can be told apart from a hold. Every cycle is judged against a behavioural model. That model finds bitmask fields by brute-force search over element size, run length and rotation, and finds range verdicts by integer arithmetic. It compares the valid pulse on every cycle, and the fields whether the block is pulsing or holding.

// File: rtl/imm_fit_pkg.sv
package imm_fit_pkg;
  localparam int unsigned DW     = 64;
  localparam int unsigned LOG_DW = $clog2(DW);
  localparam int unsigned SZ_W   = LOG_DW + 1;

  typedef enum logic [2:0] {
    K_ARITH   = 3'd0,
    K_LOGIC   = 3'd1,
    K_MOVW    = 3'd2,
    K_PCREL   = 3'd3,
    K_SHAMT   = 3'd4,
    K_LDST_SC = 3'd5,
    K_LDST_IX = 3'd6,
    K_RSVD    = 3'd7
  } imm_kind_e;

  typedef struct packed {
    logic              legal;
    logic              pattern;
    logic [LOG_DW-1:0] shift;
    logic [SZ_W-1:0]   esize;
    logic [SZ_W-1:0]   ones;
    logic [LOG_DW-1:0] rot;
  } imm_res_t;
endpackage

// File: rtl/imm_mask_decode.sv
module imm_mask_decode
  import imm_fit_pkg::*;
(
  input  logic [DW-1:0]     value_i,
  output logic              legal_o,
  output logic [SZ_W-1:0]   esize_o,
  output logic [SZ_W-1:0]   ones_o,
  output logic [LOG_DW-1:0] rot_o
);
  localparam int unsigned NS    = LOG_DW;
  localparam int unsigned SEL_W = $clog2(NS);

  logic [NS-1:0]     period_ok;
  logic [NS-1:0]     run_ok;
  logic [SZ_W-1:0]   ones_k [NS];
  logic [LOG_DW-1:0] rot_k  [NS];

  for (genvar k = 0; k < NS; k++) begin : g_size
    localparam int E = 2 << k;
    logic              run_l;
    logic [SZ_W-1:0]   ones_l;
    logic [LOG_DW-1:0] rot_l;

    if (E == DW) begin : g_full
      assign period_ok[k] = 1'b1;
    end else begin : g_part
      assign period_ok[k] = (value_i == {value_i[E-1:0], value_i[DW-1:E]});
    end

    // cyclic edge count over the element: exactly two means one run
    always_comb begin
      int                edges;
      logic [LOG_DW-1:0] start;
      edges  = 0;
      start  = '0;
      ones_l = '0;
      for (int i = 0; i < E; i++) begin
        ones_l = ones_l + SZ_W'(value_i[i]);
        if (value_i[i] != value_i[(i + 1) % E]) edges++;
        if (value_i[i] && !value_i[(i + E - 1) % E]) start = LOG_DW'(i);
      end
      run_l = (edges == 2);
      rot_l = LOG_DW'((E - int'(start)) % E);
    end

    assign run_ok[k] = run_l;
    assign ones_k[k] = ones_l;
    assign rot_k[k]  = rot_l;
  end

  logic [SEL_W-1:0] sel;
  always_comb begin
    sel = SEL_W'(NS - 1);
    for (int k = NS - 1; k >= 0; k--) begin
      if (period_ok[k]) sel = SEL_W'(k);
    end
  end

  assign legal_o = run_ok[sel];
  assign esize_o = SZ_W'(2) << sel;
  assign ones_o  = ones_k[sel];
  assign rot_o   = rot_k[sel];
endmodule

// File: rtl/imm_range_check.sv
module imm_range_check
  import imm_fit_pkg::*;
#(
  parameter int unsigned ARITH_W  = 12,
  parameter int unsigned ARITH_SH = 12,
  parameter int unsigned MOVW_W   = 16,
  parameter int unsigned PCREL_W  = 21,
  parameter int unsigned LDST_W   = 12,
  parameter int unsigned IDX_W    = 9
) (
  input  imm_kind_e         kind_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     value_i,
  output logic              fit_o,
  output logic [LOG_DW-1:0] shift_o
);
  localparam int unsigned   SLOTS   = DW / MOVW_W;
  localparam logic [DW-1:0] HW_MASK = {{(DW - MOVW_W){1'b0}}, {MOVW_W{1'b1}}};

  function automatic logic signed_fit(input logic [DW-1:0] v, input int unsigned w);
    logic [DW-1:0] top;
    top = v >> (w - 1);
    return (top == '0) || (top == ({DW{1'b1}} >> (w - 1)));
  endfunction

  logic arith_lo, arith_hi;
  assign arith_lo = ~|value_i[DW-1:ARITH_W];
  assign arith_hi = ~|value_i[DW-1:ARITH_W+ARITH_SH] & ~|value_i[ARITH_SH-1:0];

  logic [SLOTS-1:0] slot_ok;
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_ok[s] = ~|(value_i & ~(HW_MASK << (s * MOVW_W)));
  end

  logic [LOG_DW-1:0] movw_sh;
  always_comb begin
    movw_sh = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (slot_ok[s]) movw_sh = LOG_DW'(s * MOVW_W);
    end
  end

  logic [DW-1:0] low_m;
  logic          ldst_ok;
  assign low_m   = (DW'(1) << size_i) - DW'(1);
  assign ldst_ok = ~|(value_i & low_m) && (((value_i >> size_i) >> LDST_W) == '0);

  always_comb begin
    fit_o   = 1'b0;
    shift_o = '0;
    unique case (kind_i)
      K_ARITH: begin
        fit_o   = arith_lo | arith_hi;
        shift_o = arith_lo ? '0 : LOG_DW'(ARITH_SH);
      end
      K_MOVW: begin
        fit_o   = |slot_ok;
        shift_o = movw_sh;
      end
      K_PCREL:   fit_o = signed_fit(value_i, PCREL_W);
      K_SHAMT:   fit_o = ~|value_i[DW-1:LOG_DW];
      K_LDST_SC: begin
        fit_o   = ldst_ok;
        shift_o = LOG_DW'(size_i);
      end
      K_LDST_IX: fit_o = signed_fit(value_i, IDX_W);
      default:   fit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/imm_fit_checker.sv
module imm_fit_checker
  import imm_fit_pkg::*;
#(
  parameter int unsigned ARITH_W  = 12,
  parameter int unsigned ARITH_SH = 12,
  parameter int unsigned MOVW_W   = 16,
  parameter int unsigned PCREL_W  = 21,
  parameter int unsigned LDST_W   = 12,
  parameter int unsigned IDX_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_kind_i,
  input  logic [1:0]        req_size_i,
  input  logic [DW-1:0]     req_value_i,
  output logic              res_valid_o,
  output logic              res_legal_o,
  output logic              res_pattern_o,
  output logic [LOG_DW-1:0] res_shift_o,
  output logic [SZ_W-1:0]   res_esize_o,
  output logic [SZ_W-1:0]   res_ones_o,
  output logic [LOG_DW-1:0] res_rot_o
);
  imm_kind_e         kind;
  logic              accept;
  logic              mask_ok, fit;
  logic [SZ_W-1:0]   m_esize, m_ones;
  logic [LOG_DW-1:0] m_rot, fit_shift;
  imm_res_t          nxt, res_q;
  logic              valid_q;

  assign kind        = imm_kind_e'(req_kind_i);
  assign req_ready_o = 1'b1;
  assign accept      = req_valid_i & req_ready_o;

  imm_mask_decode u_mask (
    .value_i (req_value_i),
    .legal_o (mask_ok),
    .esize_o (m_esize),
    .ones_o  (m_ones),
    .rot_o   (m_rot)
  );

  imm_range_check #(
    .ARITH_W (ARITH_W), .ARITH_SH(ARITH_SH), .MOVW_W(MOVW_W),
    .PCREL_W (PCREL_W), .LDST_W  (LDST_W),   .IDX_W (IDX_W)
  ) u_range (
    .kind_i  (kind),
    .size_i  (req_size_i),
    .value_i (req_value_i),
    .fit_o   (fit),
    .shift_o (fit_shift)
  );

  // bitmask path for logical, and as move-wide fallback
  always_comb begin
    nxt = '0;
    if ((kind == K_LOGIC || (kind == K_MOVW && !fit)) && mask_ok) begin
      nxt.legal   = 1'b1;
      nxt.pattern = 1'b1;
      nxt.esize   = m_esize;
      nxt.ones    = m_ones;
      nxt.rot     = m_rot;
    end else if (kind != K_LOGIC && fit) begin
      nxt.legal = 1'b1;
      nxt.shift = fit_shift;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= accept;
      if (accept) res_q <= nxt;
    end
  end

  assign res_valid_o   = valid_q;
  assign res_legal_o   = res_q.legal;
  assign res_pattern_o = res_q.pattern;
  assign res_shift_o   = res_q.shift;
  assign res_esize_o   = res_q.esize;
  assign res_ones_o    = res_q.ones;
  assign res_rot_o     = res_q.rot;
endmodule

// File: rtl/imm_fit_checker_sva.sv
module imm_fit_checker_sva
  import imm_fit_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        req_kind_i,
  input logic [1:0]        req_size_i,
  input logic [DW-1:0]     req_value_i,
  input logic              res_valid_o,
  input logic              res_legal_o,
  input logic              res_pattern_o,
  input logic [LOG_DW-1:0] res_shift_o,
  input logic [SZ_W-1:0]   res_esize_o,
  input logic [SZ_W-1:0]   res_ones_o,
  input logic [LOG_DW-1:0] res_rot_o
);
  AST_PULSE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> res_valid_o); // R1

  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !res_valid_o); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable({res_legal_o, res_pattern_o, res_shift_o,
                              res_esize_o, res_ones_o, res_rot_o})); // R1

  AST_ARITH_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_legal_o && $past(req_kind_i) == K_ARITH)
      |-> (res_shift_o == 6'd0 || res_shift_o == 6'd12)); // R2

  AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_legal_o && res_pattern_o)
      |-> ($countones(res_esize_o) == 1 && res_esize_o >= 7'd2 && res_ones_o != '0 &&
           res_ones_o < res_esize_o && SZ_W'(res_rot_o) < res_esize_o)); // R4

  AST_SHAMT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(req_kind_i) == K_SHAMT)
      |-> (res_legal_o == ($past(req_value_i) < 64'd64))); // R8

  AST_SCALE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_legal_o && $past(req_kind_i) == K_LDST_SC)
      |-> (res_shift_o == LOG_DW'($past(req_size_i)))); // R9

  AST_RSVD_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(req_kind_i) == K_RSVD) |-> !res_legal_o); // R11

  AST_ILLEGAL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_legal_o |-> (!res_pattern_o && res_shift_o == '0 && res_esize_o == '0 &&
                      res_ones_o == '0 && res_rot_o == '0)); // R11
endmodule

bind imm_fit_checker imm_fit_checker_sva u_sva (.*);

// File: tb/imm_fit_checker_bench.sv
`timescale 1ns/100ps
module imm_fit_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_value = '0;
  logic        res_valid, res_legal, res_pattern;
  logic [5:0]  res_shift, res_rot;
  logic [6:0]  res_esize, res_ones;

  always #2.5 clk = ~clk;

  imm_fit_checker u_imm_fit_checker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_size_i(req_size), .req_value_i(req_value),
    .res_valid_o(res_valid), .res_legal_o(res_legal), .res_pattern_o(res_pattern),
    .res_shift_o(res_shift), .res_esize_o(res_esize), .res_ones_o(res_ones),
    .res_rot_o(res_rot)
  );

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  bit e_valid = 0, e_legal = 0, e_pat = 0;
  int e_shift = 0, e_esize = 0, e_ones = 0, e_rot = 0;
  string e_tag = "R1";
  logic [63:0] lfsr = 64'h9e3779b97f4a7c15;

  function automatic logic [63:0] build_mask(int e, int o, int r);
    logic [63:0] emask, base, elem, full;
    emask = (e == 64) ? '1 : ((64'd1 << e) - 64'd1);
    base  = (64'd1 << o) - 64'd1;
    elem  = ((base >> r) | (base << (e - r))) & emask;
    full  = '0;
    for (int p = 0; p < 64; p += e) full |= elem << p;
    return full;
  endfunction

  function automatic bit ref_mask(logic [63:0] v, output int e_o, output int o_o, output int r_o);
    e_o = 0; o_o = 0; r_o = 0;
    for (int e = 2; e <= 64; e *= 2)
      for (int o = 1; o < e; o++)
        for (int r = 0; r < e; r++)
          if (build_mask(e, o, r) == v) begin
            e_o = e; o_o = o; r_o = r;
            return 1'b1;
          end
    return 1'b0;
  endfunction

  task automatic ref_eval(int kind, int sz, logic [63:0] v);
    longint sv;
    int me, mo, mr;
    bit mok;
    sv = v;
    e_legal = 0; e_pat = 0; e_shift = 0; e_esize = 0; e_ones = 0; e_rot = 0;
    case (kind)
      0: begin
        e_tag = "R2";
        if (v <= 64'hfff) e_legal = 1;
        else if (v[11:0] == 0 && (v >> 12) <= 64'hfff) begin e_legal = 1; e_shift = 12; end
      end
      1, 2: begin
        e_tag = (kind == 1) ? "R3" : "R5";
        if (kind == 2)
          for (int s = 48; s >= 0; s -= 16)
            if (((v >> s) << s) == v && (v >> s) <= 64'hffff) begin e_legal = 1; e_shift = s; end
        if (!e_legal) begin
          mok = ref_mask(v, me, mo, mr);
          if (mok) begin
            e_legal = 1; e_pat = 1; e_esize = me; e_ones = mo; e_rot = mr;
            e_tag = (kind == 1) ? "R4" : "R6";
          end
        end
      end
      3: begin e_tag = "R7"; e_legal = (sv >= -64'sh100000 && sv <= 64'shfffff); end
      4: begin e_tag = "R8"; e_legal = (v <= 64'd63); end
      5: begin
        e_tag = "R9";
        if ((v % (64'd1 << sz)) == 0 && (v / (64'd1 << sz)) <= 64'hfff) begin
          e_legal = 1; e_shift = sz;
        end
      end
      6: begin e_tag = "R10"; e_legal = (sv >= -64'sd256 && sv <= 64'sd255); end
      default: e_tag = "R11";
    endcase
    if (!e_legal && kind != 0 && kind != 3 && kind != 4 && kind != 6) e_tag = (kind == 7) ? "R11" : e_tag;
  endtask

  task automatic compare();
    compared++;
    if (res_valid !== e_valid) begin
      mismatched++;
      $display("FAIL R1 res_valid actual=%0b expected=%0b", res_valid, e_valid);
    end else if (res_legal !== e_legal || res_pattern !== e_pat || int'(res_shift) != e_shift ||
                 int'(res_esize) != e_esize || int'(res_ones) != e_ones || int'(res_rot) != e_rot) begin
      mismatched++;
      $display("FAIL %s actual legal=%0b pat=%0b sh=%0d es=%0d on=%0d rot=%0d expected legal=%0b pat=%0b sh=%0d es=%0d on=%0d rot=%0d (R11 fields)",
               e_tag, res_legal, res_pattern, res_shift, res_esize, res_ones, res_rot,
               e_legal, e_pat, e_shift, e_esize, e_ones, e_rot);
    end
  endtask

  task automatic step(bit vld, int kind, int sz, logic [63:0] v);
    @(negedge clk);
    compare();
    req_valid = vld; req_kind = 3'(kind); req_size = 2'(sz); req_value = v;
    e_valid = vld;
    if (vld) ref_eval(kind, sz, v);
  endtask

  function automatic logic [63:0] next_rand();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 7;
    lfsr ^= lfsr << 17;
    return lfsr;
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare(); // R1 reset state all zero
    end
    rst_n = 1'b1;
    // R2 arithmetic
    step(1, 0, 0, 64'hfff);     step(1, 0, 0, 64'h1fff);
    step(1, 0, 0, 64'h0);       step(1, 0, 0, 64'hfff000);
    step(1, 0, 0, 64'hfff001);  step(1, 0, 0, 64'h1000000);
    // R3 R4 logical
    step(1, 1, 0, 64'hf0f0f0f0f0f0f0f0); step(1, 1, 0, 64'hfeedfeedfeedfeed);
    step(1, 1, 0, 64'h0);                step(1, 1, 0, '1);
    step(1, 1, 0, 64'h5555555555555555); step(1, 1, 0, 64'h1);
    step(1, 1, 0, 64'h8000000000000001); step(1, 1, 0, 64'h00ff00ff00ff00ff);
    // R1 hold across idle gaps
    step(0, 1, 0, 64'h0); step(0, 7, 0, 64'h3); step(0, 0, 0, 64'h0);
    // R5 R6 move-wide
    step(1, 2, 0, 64'h8765);             step(1, 2, 0, 64'h88888);
    step(1, 2, 0, 64'hffff0000);         step(1, 2, 0, 64'h1234000000000000);
    step(1, 2, 0, 64'h0);                step(1, 2, 0, 64'hf0f0f0f0f0f0f0f0);
    step(1, 2, 0, 64'h10001);
    // R7 PC-relative
    step(1, 3, 0, -64'sh100000); step(1, 3, 0, -64'sh100001);
    step(1, 3, 0, 64'hfffff);    step(1, 3, 0, 64'h100000);
    // R8 shift amount
    step(1, 4, 0, 64'd7); step(1, 4, 0, 64'd63); step(1, 4, 0, 64'd64); step(1, 4, 0, 64'h4f);
    // R9 scaled offsets
    step(1, 5, 3, 64'h7ff8); step(1, 5, 3, 64'h7ff4); step(1, 5, 0, 64'hfff);
    step(1, 5, 0, 64'h1000); step(1, 5, 1, 64'h1ffe); step(1, 5, 1, 64'h3);
    step(1, 5, 2, 64'h3ffc); step(1, 5, 2, 64'h4000);
    // R10 indexed
    step(1, 6, 0, -64'sh0ff); step(1, 6, 0, 64'h1ff); step(1, 6, 0, 64'd255);
    step(1, 6, 0, -64'sd256); step(1, 6, 0, -64'sd257);
    // R11 reserved kind
    step(1, 7, 0, 64'h0); step(0, 0, 0, 64'h0);
    // mixed bursts and gaps
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r, v;
      int kind, e;
      r = next_rand();
      kind = int'(r[2:0]);
      case (r[5:4])
        2'd0: v = {52'd0, r[63:52]};
        2'd1: begin
          e = 2 << (int'(r[10:8]) % 6);
          v = build_mask(e, 1 + int'(r[30:24]) % (e - 1), int'(r[40:34]) % e);
        end
        2'd2: v = r[63] ? ~{55'd0, r[63:55]} : {55'd0, r[63:55]};
        default: v = next_rand();
      endcase
      step(r[12:11] != 2'b00, kind, int'(r[14:13]), v);
    end
    step(0, 0, 0, 64'h0);
    step(0, 0, 0, 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule